// File: doc/BRIEF.md
# Condition Code and Branch Mask Unit

This block is a small integer execution stage for two's-complement operands. It accepts one operation at a time (add, signed compare or load-positive) over a valid/ready request channel. It returns the result over a valid/ready result channel. The add, compare and load-positive operations also record a 2-bit condition code, whose meaning depends on the operation that produced it.

A separate, plain control path performs branch tests. When `br_test` is high, the 4-bit `br_mask` is matched against the stored condition code. One cycle later, `br_taken` reports whether any selected code matches. Fetch, decode, target address computation and the program counter belong to the surrounding pipeline. This block only produces the decision.

Back-pressure rules: a request is accepted on a rising edge where `op_valid` and `op_ready` are both high. `op_ready` is high whenever the one-entry result register is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result stays frozen and no new request is accepted.

Top module: `cond_branch_unit`

## Requirements
- R1: After a synchronous reset, `cc` is 0, `br_taken` is 0, `res_valid` is 0 and `op_ready` is 1.
- R2: `op_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays unchanged.
- R3: Add (`op_code` 0) returns `opnd_a + opnd_b` modulo 2^WIDTH. Without overflow, it sets `cc` to 0 for a zero sum, 1 for a negative sum and 2 for a positive sum.
- R4: Add sets `cc` to 3 when both operands have the same sign and the sum's sign differs. This takes priority even when the wrapped sum is zero.
- R5: Compare (`op_code` 1) returns `opnd_a` unchanged. It sets `cc` to 0 when the operands are equal, 1 when `opnd_a` is lower and 2 when `opnd_a` is higher, using signed order.
- R6: Load-positive (`op_code` 2) returns `opnd_a` when it is non-negative and its two's complement when it is negative, setting `cc` to 0 for zero and 2 otherwise. The most negative value returns itself with `cc` 3.
- R7: A branch test samples `br_test` and `br_mask` on a rising edge. After that edge, `br_taken` is high only if `br_mask[3-cc]` was set, where `cc` is the stored code. `br_taken` is 0 after any edge where `br_test` was low.
- R8: A mask of 0 never sets `br_taken`. A mask of 15 always sets it.
- R9: The condition code changes on the same edge that accepts the operation. A branch test on that edge uses the code stored before the operation.
- R10: `cc` changes only on an accepted add, compare or load-positive. The reserved `op_code` 3 returns 0 and leaves `cc` unchanged, and a request held off by `op_ready` low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Unit can accept a request this cycle |
| op_code | input | 2 | 0 add, 1 compare, 2 load-positive, 3 reserved |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (unused by load-positive) |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | WIDTH | Operation result |
| cc | output | 2 | Stored condition code |
| br_test | input | 1 | Branch-test strobe |
| br_mask | input | 4 | Branch mask, bit 3 selects code 0 and bit 0 selects code 3 |
| br_taken | output | 1 | Registered branch decision |

## Verification
A corrupted condition code register appears directly on `cc`. It also shows up in the branch decision one cycle after the next strobe, so every code value is swept against all sixteen masks. A wrong ALU code or result is caught when the result handshake completes, because the scoreboard compares `cc` and `res_data` together at that point. A broken stall shows up within the stalled cycles as a moving `res_data` or an early `op_ready`. A lagging or early code update shows up in the same-cycle branch test.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int CC_W   = 2;
  localparam int MASK_W = 1 << CC_W;

  typedef logic [CC_W-1:0] cc_t;

  typedef enum logic [1:0] {
    OPC_ADD  = 2'd0,
    OPC_CMP  = 2'd1,
    OPC_LPOS = 2'd2,
    OPC_RSV  = 2'd3
  } opc_e;
endpackage

// File: rtl/ccu_alu.sv
module ccu_alu
  import ccu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  opc_e             op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output cc_t              cc_nxt,
  output logic             cc_we
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] neg_a;
  logic             add_ovf;
  logic             lpos_ovf;
  logic             a_lt_b;

  assign sum      = a + b;
  assign neg_a    = (~a) + {{(WIDTH-1){1'b0}}, 1'b1};
  assign add_ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign lpos_ovf = a[MSB] && neg_a[MSB];
  assign a_lt_b   = $signed(a) < $signed(b);

  always_comb begin
    result = '0;
    cc_nxt = '0;
    cc_we  = 1'b0;
    unique case (op)
      OPC_ADD: begin
        result = sum;
        cc_we  = 1'b1;
        if (add_ovf)          cc_nxt = 2'd3;
        else if (sum == '0)   cc_nxt = 2'd0;
        else if (sum[MSB])    cc_nxt = 2'd1;
        else                  cc_nxt = 2'd2;
      end
      OPC_CMP: begin
        result = a;
        cc_we  = 1'b1;
        if (a == b)           cc_nxt = 2'd0;
        else if (a_lt_b)      cc_nxt = 2'd1;
        else                  cc_nxt = 2'd2;
      end
      OPC_LPOS: begin
        result = a[MSB] ? neg_a : a;
        cc_we  = 1'b1;
        if (lpos_ovf)         cc_nxt = 2'd3;
        else if (a == '0)     cc_nxt = 2'd0;
        else                  cc_nxt = 2'd2;
      end
      default: begin
        result = '0;
        cc_we  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ccu_mask_match.sv
module ccu_mask_match
  import ccu_pkg::*;
(
  input  cc_t               cc,
  input  logic [MASK_W-1:0] mask,
  output logic              hit
);
  logic [MASK_W-1:0] sel;

  // leftmost mask bit pairs with code 0, rightmost with the highest code
  for (genvar i = 0; i < MASK_W; i++) begin : g_code
    assign sel[i] = mask[MASK_W-1-i] && (cc == CC_W'(i));
  end

  assign hit = |sel;
endmodule

// File: rtl/ccu_out_stage.sv
module ccu_out_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             vld_q;
  logic [WIDTH-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      dat_q <= in_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import ccu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_code,
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WIDTH-1:0]  res_data,
  output logic [CC_W-1:0]   cc,
  input  logic              br_test,
  input  logic [MASK_W-1:0] br_mask,
  output logic              br_taken
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic             op_fire;
  logic [WIDTH-1:0] alu_res;
  cc_t              cc_nxt;
  logic             cc_we;
  cc_t              cc_q;
  logic             br_hit;
  logic             br_q;

  assign op_fire = op_valid && op_ready;

  ccu_alu #(.WIDTH(WIDTH)) u_alu (
    .op     (opc_e'(op_code)),
    .a      (opnd_a),
    .b      (opnd_b),
    .result (alu_res),
    .cc_nxt (cc_nxt),
    .cc_we  (cc_we)
  );

  ccu_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (op_valid),
    .in_ready  (op_ready),
    .in_data   (alu_res),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (res_data)
  );

  // code register: written on the edge that accepts a code-setting op
  always_ff @(posedge clk) begin
    if (rst)                    cc_q <= '0;
    else if (op_fire && cc_we)  cc_q <= cc_nxt;
  end

  // branch test reads the code as stored before this edge
  ccu_mask_match u_match (
    .cc   (cc_q),
    .mask (br_mask),
    .hit  (br_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) br_q <= 1'b0;
    else     br_q <= br_test && br_hit;
  end

  assign cc       = cc_q;
  assign br_taken = br_q;

  // ---------------- assertions ----------------
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  p_cmp_pass_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_ready && op_code == 2'd1 |=> res_valid && res_data == $past(opnd_a));

  p_lpos_nonneg_r6: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_ready && op_code == 2'd2 && opnd_a != MOST_NEG |=> !res_data[WIDTH-1]);

  p_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !br_test |=> !br_taken);

  p_mask_zero_r8: assert property (@(posedge clk) disable iff (rst)
    br_test && br_mask == '0 |=> !br_taken);

  p_mask_full_r8: assert property (@(posedge clk) disable iff (rst)
    br_test && br_mask == '1 |=> br_taken);

  p_cc_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_ready) |=> $stable(cc));

  p_cc_rsv_r10: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_ready && op_code == 2'd3 |=> $stable(cc));
endmodule

// File: tb/cond_branch_unit_test.sv
module cond_branch_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [1:0]   op_code = 2'd0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [W-1:0] res_data;
  logic [1:0]   cc;
  logic         br_test = 1'b0;
  logic [3:0]   br_mask = 4'd0;
  logic         br_taken;

  int ntot = 0;
  int nbad = 0;
  logic [1:0] mcc = 2'd0;

  typedef struct {
    logic [W-1:0] d;
    logic [1:0]   c;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  cond_branch_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .cc(cc), .br_test(br_test), .br_mask(br_mask), .br_taken(br_taken)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input logic [1:0] oc, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] prev, output logic [W-1:0] d, output logic [1:0] c);
    logic [W-1:0] s;
    c = prev;
    d = '0;
    case (oc)
      2'd0: begin
        s = a + b;
        d = s;
        if (a[W-1] == b[W-1] && s[W-1] != a[W-1]) c = 2'd3;
        else if (s == 0) c = 2'd0;
        else if (s[W-1]) c = 2'd1;
        else c = 2'd2;
      end
      2'd1: begin
        d = a;
        if (a == b) c = 2'd0;
        else if ($signed(a) < $signed(b)) c = 2'd1;
        else c = 2'd2;
      end
      2'd2: begin
        if (a == 32'h8000_0000) begin d = a; c = 2'd3; end
        else if (a[W-1]) begin d = 0 - a; c = 2'd2; end
        else begin d = a; c = (a == 0) ? 2'd0 : 2'd2; end
      end
      default: begin d = '0; c = prev; end
    endcase
  endtask

  task automatic send_op(input logic [1:0] oc, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string tag);
    exp_t e;
    @(negedge clk);
    op_code = oc; opnd_a = a; opnd_b = b; op_valid = 1'b1;
    #1;
    while (!op_ready) begin @(negedge clk); #1; end
    model(oc, a, b, mcc, e.d, e.c);
    e.tag = tag;
    mcc = e.c;
    q.push_back(e);
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic br_check(input logic [3:0] m);
    logic ex;
    ex = m[3 - mcc];
    @(negedge clk);
    br_test = 1'b1; br_mask = m;
    @(negedge clk);
    br_test = 1'b0;
    #2 chk($sformatf("R7 R8 mask=%0d cc=%0d", m, mcc), {31'd0, br_taken}, {31'd0, ex});
    @(negedge clk);
    #2 chk("R7 no strobe", {31'd0, br_taken}, 32'd0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && res_valid && res_ready) begin
        if (q.size() == 0) begin
          ntot++; nbad++;
          $display("FAIL R2 unexpected result act=%h exp=none", res_data);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " data"}, res_data, e.d);
          chk({e.tag, " cc"}, {30'd0, cc}, {30'd0, e.c});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    ntot++; nbad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R1 cc", {30'd0, cc}, 32'd0);
    chk("R1 br_taken", {31'd0, br_taken}, 32'd0);
    chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 op_ready", {31'd0, op_ready}, 32'd1);
    res_ready = 1'b1;

    send_op(2'd0, 32'd3, 32'd4, "R3 pos");
    send_op(2'd0, 32'd5, 32'hFFFF_FFFB, "R3 zero");
    send_op(2'd0, 32'd2, 32'hFFFF_FFF7, "R3 neg");
    send_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 neg2");
    send_op(2'd0, 32'h7FFF_FFFF, 32'd1, "R4 ovf");
    send_op(2'd0, 32'h8000_0000, 32'h8000_0000, "R4 ovf zero");
    send_op(2'd1, 32'd1, 32'd2, "R5 lt");
    send_op(2'd1, 32'd2, 32'd1, "R5 gt");
    send_op(2'd1, 32'd7, 32'd7, "R5 eq");
    send_op(2'd1, 32'hFFFF_FFFD, 32'd2, "R5 signed lt");
    send_op(2'd1, 32'd5, 32'h8000_0000, "R5 signed gt");
    send_op(2'd2, 32'hFFFF_FFFD, 32'd0, "R6 neg");
    send_op(2'd2, 32'd0, 32'd9, "R6 zero");
    send_op(2'd2, 32'd42, 32'd0, "R6 pos");
    send_op(2'd2, 32'h8000_0000, 32'd0, "R6 most neg");
    send_op(2'd0, 32'd1, 32'd0, "R3 set cc2");
    send_op(2'd3, 32'd11, 32'd12, "R10 reserved");
    drain();

    // stall: result must hold, code must not move, request must wait
    res_ready = 1'b0;
    send_op(2'd0, 32'd5, 32'hFFFF_FFF7, "R2 stalled add");
    @(negedge clk);
    op_code = 2'd1; opnd_a = 32'd1; opnd_b = 32'd1; op_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #2;
      chk("R2 hold valid", {31'd0, res_valid}, 32'd1);
      chk("R2 hold data", res_data, 32'hFFFF_FFFC);
      chk("R2 not ready", {31'd0, op_ready}, 32'd0);
      chk("R10 cc held while stalled", {30'd0, cc}, {30'd0, mcc});
    end
    begin
      exp_t e;
      model(2'd1, 32'd1, 32'd1, mcc, e.d, e.c);
      e.tag = "R2 released cmp";
      mcc = e.c;
      q.push_back(e);
    end
    @(negedge clk);
    res_ready = 1'b1;
    @(posedge clk);
    #1 op_valid = 1'b0;
    drain();

    // sweep every code against every mask
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: send_op(2'd1, 32'd4, 32'd4, "R5 set cc0");
        1: send_op(2'd1, 32'd1, 32'd4, "R5 set cc1");
        2: send_op(2'd1, 32'd9, 32'd4, "R5 set cc2");
        default: send_op(2'd0, 32'h7FFF_FFFF, 32'd5, "R4 set cc3");
      endcase
      drain();
      for (int m = 0; m < 16; m++) br_check(4'(m));
    end

    // same-edge op and branch test: test sees the old code (3)
    @(negedge clk);
    op_code = 2'd1; opnd_a = 32'd1; opnd_b = 32'd1; op_valid = 1'b1;
    br_test = 1'b1; br_mask = 4'b0001;
    begin
      exp_t e;
      model(2'd1, 32'd1, 32'd1, mcc, e.d, e.c);
      e.tag = "R9 cmp";
      mcc = e.c;
      q.push_back(e);
    end
    @(posedge clk);
    #1 op_valid = 1'b0;
    @(negedge clk);
    br_test = 1'b0;
    #2;
    chk("R9 old code used", {31'd0, br_taken}, 32'd1);
    chk("R9 new code stored", {30'd0, cc}, 32'd0);
    drain();
    br_check(4'b0001);
    br_check(4'b1000);

    drain();
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule